// File: doc/BRIEF.md
# Protection Region Register Bank

This block is the software-visible configuration store of a memory protection unit with a configurable number of regions (1 to 16). A single-cycle request port carries a 12-bit word offset, a write flag and 32 bits of write data. Each accepted request is answered one clock later by a one-cycle response that carries read data and error flags. The bank holds four kinds of state: a read-only type word, a control word, a region pointer, and one base word and one attribute/size word for each region. Base and attribute accesses go to the region that the pointer selects. A base write can also move the pointer through its valid bit. Three alias offset pairs reach the same base/attribute pair, so software can stream several regions in a burst of stores.

The decoded configuration leaves the block on flat vectors that feed a separate region-checking block: the per-region base, size half and attribute half, and the three control bits. A one-cycle pulse tells that checker that the protection configuration has changed, so it can drop any cached decisions.

The port is run by a two-state machine. `ST_IDLE` holds `req_ready` high. A request with `req_valid` high takes the transition `T_ACCEPT` to `ST_RESP`. `ST_RESP` drives `rsp_valid` for exactly one cycle with `req_ready` low, then takes the transition `T_DONE` back to `ST_IDLE`.

Top module: `prot_region_regs`

## Requirements
- R1: While the port is idle, `req_ready` is high. A request presented with `req_ready` high is accepted at that clock edge. `rsp_valid` is then high for exactly the next cycle, and `req_ready` is low during that cycle. `rsp_rdata` is zero for writes.
- R2: After reset, all control outputs, the region pointer and every exported region field are zero, `req_ready` is high and `rsp_valid` is low.
- R3: The type word at offset 0xD90 reads as NUM_REGIONS in bits [15:8] and zero in all other bits. A write to it changes nothing and raises no flag.
- R4: The control word at 0xD94 stores only bit 0 (enable), bit 1 (enable inside fault/NMI handlers) and bit 2 (privileged default-map enable). Other written bits read back as zero. The stored bits drive `ctrl_enable`, `ctrl_fault_en` and `ctrl_priv_default` respectively.
- R5: A control write with bit 1 = 1 and bit 0 = 0 raises `rsp_err_cfg`, and the value is still stored.
- R6: The pointer word at 0xD98 accepts a write whose full 32-bit value is below NUM_REGIONS. A larger or equal value raises `rsp_err_cfg` and leaves the pointer unchanged. A read returns the pointer in bits [3:0].
- R7: A base write at 0xD9C, 0xDA4, 0xDAC or 0xDB4 stores the data with bits [4:0] cleared. A read at any of these offsets returns the stored base in bits [31:5] and the current pointer in bits [3:0].
- R8: When bit 4 of a base write is set, bits [3:0] name the target region and are copied into the pointer. If that region is not below NUM_REGIONS, the whole write is dropped and `rsp_err_cfg` is raised.
- R9: An attribute write at 0xDA0, 0xDA8, 0xDB0 or 0xDB8 stores bits [15:0] masked with 0xFF3F as the size half and bits [31:16] masked with 0x173F as the attribute half. A read returns {attribute half, size half}.
- R10: `cfg_changed` is high for one cycle, together with `rsp_valid`, after every accepted control, base or attribute write. Pointer writes, type writes, dropped writes and reads give no pulse.
- R11: An access to any other offset returns zero read data, raises `rsp_err_decode` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err_cfg | output | 1 | Rejected or unpredictable configuration value |
| rsp_err_decode | output | 1 | Offset not mapped |
| cfg_changed | output | 1 | Protection configuration changed |
| ctrl_enable | output | 1 | Protection enable |
| ctrl_fault_en | output | 1 | Enable inside fault/NMI handlers |
| ctrl_priv_default | output | 1 | Privileged default-map enable |
| region_base | output | 32*NUM_REGIONS | Base word of region i at [32*i +: 32] |
| region_size | output | 16*NUM_REGIONS | Size half of region i at [16*i +: 16] |
| region_attr | output | 16*NUM_REGIONS | Attribute half of region i at [16*i +: 16] |

## Verification
Every result of a request is due in the single cycle after the accepting edge. Read data, both error flags and the change pulse are registered there, and the stored configuration outputs switch at that same edge. The bench drives a request at a falling edge, so it is accepted at the next rising edge. It then samples all responses and exported fields at the following falling edge, where `rsp_valid` must be high. One further falling edge later it checks that the port has returned to idle. Effects that must be absent, such as rejected pointers, dropped base writes and writes to unmapped offsets, are confirmed by reading the affected word back or by looking at the exported vectors.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned PTR_W   = 4;
    localparam int unsigned HALF_W  = 16;

    localparam logic [15:0] SIZE_KEEP = 16'hFF3F;
    localparam logic [15:0] ATTR_KEEP = 16'h173F;
    localparam logic [2:0]  CTRL_KEEP = 3'b111;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_CTRL,
        SEL_PTR,
        SEL_BASE,
        SEL_ATTR
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

endpackage

// File: rtl/prot_region_decode.sv
module prot_region_decode
    import prot_region_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            12'hD90:                            sel = SEL_TYPE;
            12'hD94:                            sel = SEL_CTRL;
            12'hD98:                            sel = SEL_PTR;
            12'hD9C, 12'hDA4, 12'hDAC, 12'hDB4: sel = SEL_BASE;
            12'hDA0, 12'hDA8, 12'hDB0, 12'hDB8: sel = SEL_ATTR;
            default:                            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/prot_region_port_fsm.sv
module prot_region_port_fsm
    import prot_region_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic rsp_valid,
    output logic accept
);

    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // T_ACCEPT
            ST_RESP: state_d = ST_IDLE;                  // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
        accept = req_ready & req_valid;
    end

endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
    import prot_region_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_attr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base,
    output logic [HALF_W-1:0] size,
    output logic [HALF_W-1:0] attr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            size <= '0;
            attr <= '0;
        end else begin
            if (wr_base) base <= {wdata[DATA_W-1:5], 5'b0};
            if (wr_attr) begin
                size <= wdata[HALF_W-1:0] & SIZE_KEEP;
                attr <= wdata[DATA_W-1:HALF_W] & ATTR_KEEP;
            end
        end
    end

endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
    import prot_region_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [11:0]                   req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    output logic                          rsp_err_cfg,
    output logic                          rsp_err_decode,
    output logic                          cfg_changed,
    output logic                          ctrl_enable,
    output logic                          ctrl_fault_en,
    output logic                          ctrl_priv_default,
    output logic [32*NUM_REGIONS-1:0]     region_base,
    output logic [16*NUM_REGIONS-1:0]     region_size,
    output logic [16*NUM_REGIONS-1:0]     region_attr
);

    localparam logic [DATA_W-1:0] COUNT_W32 = DATA_W'(NUM_REGIONS);
    localparam logic [PTR_W:0]    COUNT_W5  = (PTR_W+1)'(NUM_REGIONS);
    localparam logic [DATA_W-1:0] TYPE_WORD = COUNT_W32 << 8;

    logic             accept;
    reg_sel_e         sel;
    logic [PTR_W-1:0] cur_region;
    logic [2:0]       ctrl_q;

    logic [DATA_W-1:0] slot_base [NUM_REGIONS];
    logic [HALF_W-1:0] slot_size [NUM_REGIONS];
    logic [HALF_W-1:0] slot_attr [NUM_REGIONS];

    prot_region_port_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .accept    (accept)
    );

    prot_region_decode u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    // Write qualification
    logic             wr_acc, sel_valid, vreg_ok, ptr_ok, base_ok;
    logic [PTR_W-1:0] vreg, base_target;
    logic             wr_ctrl, wr_ptr_ok, wr_base_ok, wr_attr_ok;
    logic             err_cfg_d, err_dec_d, changed_d;
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        wr_acc      = accept & req_write;
        sel_valid   = req_wdata[4];
        vreg        = req_wdata[PTR_W-1:0];
        vreg_ok     = {1'b0, vreg} < COUNT_W5;
        ptr_ok      = {1'b0, cur_region} < COUNT_W5;
        base_ok     = sel_valid ? vreg_ok : ptr_ok;
        base_target = sel_valid ? vreg : cur_region;

        wr_ctrl    = wr_acc && (sel == SEL_CTRL);
        wr_ptr_ok  = wr_acc && (sel == SEL_PTR) && (req_wdata < COUNT_W32);
        wr_base_ok = wr_acc && (sel == SEL_BASE) && base_ok;
        wr_attr_ok = wr_acc && (sel == SEL_ATTR) && ptr_ok;

        err_cfg_d = 1'b0;
        if (wr_ctrl && req_wdata[1:0] == 2'b10)                   err_cfg_d = 1'b1;
        if (wr_acc && sel == SEL_PTR && !(req_wdata < COUNT_W32)) err_cfg_d = 1'b1;
        if (wr_acc && sel == SEL_BASE && sel_valid && !vreg_ok)   err_cfg_d = 1'b1;

        err_dec_d = accept && (sel == SEL_NONE);
        changed_d = wr_ctrl | wr_base_ok | wr_attr_ok;
    end

    // Region storage
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
        logic hit_base, hit_attr;
        assign hit_base = wr_base_ok && (base_target == PTR_W'(g));
        assign hit_attr = wr_attr_ok && (cur_region == PTR_W'(g));

        prot_region_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (hit_base),
            .wr_attr (hit_attr),
            .wdata   (req_wdata),
            .base    (slot_base[g]),
            .size    (slot_size[g]),
            .attr    (slot_attr[g])
        );

        assign region_base[32*g +: 32] = slot_base[g];
        assign region_size[16*g +: 16] = slot_size[g];
        assign region_attr[16*g +: 16] = slot_attr[g];
    end

    // Control and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            cur_region <= '0;
        end else begin
            if (wr_ctrl)         ctrl_q     <= req_wdata[2:0] & CTRL_KEEP;
            if (wr_ptr_ok)       cur_region <= req_wdata[PTR_W-1:0];
            else if (wr_base_ok && sel_valid) cur_region <= vreg;
        end
    end

    assign ctrl_enable       = ctrl_q[0];
    assign ctrl_fault_en     = ctrl_q[1];
    assign ctrl_priv_default = ctrl_q[2];

    // Read mux
    logic [DATA_W-1:0] sel_base;
    logic [HALF_W-1:0] sel_size, sel_attr;

    always_comb begin
        sel_base = '0;
        sel_size = '0;
        sel_attr = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cur_region == PTR_W'(i)) begin
                sel_base = slot_base[i];
                sel_size = slot_size[i];
                sel_attr = slot_attr[i];
            end
        end

        rdata_d = '0;
        if (!req_write) begin
            unique case (sel)
                SEL_TYPE: rdata_d = TYPE_WORD;
                SEL_CTRL: rdata_d = {29'b0, ctrl_q};
                SEL_PTR:  rdata_d = {28'b0, cur_region};
                SEL_BASE: rdata_d = ptr_ok ? (sel_base | {28'b0, cur_region}) : '0;
                SEL_ATTR: rdata_d = ptr_ok ? {sel_attr, sel_size} : '0;
                default:  rdata_d = '0;
            endcase
        end
    end

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata      <= '0;
            rsp_err_cfg    <= 1'b0;
            rsp_err_decode <= 1'b0;
            cfg_changed    <= 1'b0;
        end else begin
            rsp_rdata      <= accept ? rdata_d : '0;
            rsp_err_cfg    <= accept & err_cfg_d;
            rsp_err_decode <= err_dec_d;
            cfg_changed    <= accept & changed_d;
        end
    end

endmodule

// File: rtl/prot_region_regs_chk.sv
module prot_region_regs_chk #(
    parameter int unsigned NUM_REGIONS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err_decode,
    input logic        cfg_changed,
    input logic        ctrl_enable,
    input logic        ctrl_fault_en,
    input logic        ctrl_priv_default,
    input logic [3:0]  cur_region
);

    p_accept_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_resp_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        {28'b0, cur_region} < NUM_REGIONS);

    p_ctrl_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctrl_enable, ctrl_fault_en, ctrl_priv_default}) |-> (rsp_valid && cfg_changed));

    p_pulse_in_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_changed |-> rsp_valid);

    p_decode_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_decode |-> (rsp_rdata == 32'b0 && !cfg_changed));

endmodule

bind prot_region_regs prot_region_regs_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .rsp_valid         (rsp_valid),
    .rsp_rdata         (rsp_rdata),
    .rsp_err_decode    (rsp_err_decode),
    .cfg_changed       (cfg_changed),
    .ctrl_enable       (ctrl_enable),
    .ctrl_fault_en     (ctrl_fault_en),
    .ctrl_priv_default (ctrl_priv_default),
    .cur_region        (cur_region)
);

// File: tb/prot_region_regs_tb.sv
module prot_region_regs_tb;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err_cfg, rsp_err_decode, cfg_changed;
    logic [31:0]   rsp_rdata;
    logic          ctrl_enable, ctrl_fault_en, ctrl_priv_default;
    logic [32*N-1:0] region_base;
    logic [16*N-1:0] region_size, region_attr;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    prot_region_regs #(.NUM_REGIONS(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err_cfg(rsp_err_cfg), .rsp_err_decode(rsp_err_decode),
        .cfg_changed(cfg_changed),
        .ctrl_enable(ctrl_enable), .ctrl_fault_en(ctrl_fault_en),
        .ctrl_priv_default(ctrl_priv_default),
        .region_base(region_base), .region_size(region_size), .region_attr(region_attr)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
        end
    endtask

    logic [31:0] r_data;
    logic        r_ecfg, r_edec, r_chg, r_valid, r_ready;

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        r_data = rsp_rdata; r_ecfg = rsp_err_cfg; r_edec = rsp_err_decode;
        r_chg = cfg_changed; r_valid = rsp_valid; r_ready = req_ready;
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R2 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R2 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        chk("R2 ctrl outputs", {29'b0, ctrl_priv_default, ctrl_fault_en, ctrl_enable}, 32'd0);
        chk("R2 region_base zero", {31'b0, region_base == '0}, 32'd1);
        chk("R2 region_size/attr zero", {31'b0, (region_size | region_attr) == '0}, 32'd1);
        access(1'b0, 12'hD98, 0);
        chk("R2 pointer reads zero", r_data, 32'd0);
    endtask

    task automatic t_handshake;
        access(1'b0, 12'hD94, 0);
        chk("R1 rsp_valid in response cycle", {31'b0, r_valid}, 32'd1);
        chk("R1 ready low in response cycle", {31'b0, r_ready}, 32'd0);
        @(negedge clk);
        chk("R1 rsp_valid drops after one cycle", {31'b0, rsp_valid}, 32'd0);
        chk("R1 ready back in idle", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_type;
        access(1'b0, 12'hD90, 0);
        chk("R3 type word", r_data, 32'(N) << 8);
        access(1'b1, 12'hD90, 32'hFFFF_FFFF);
        chk("R3 type write no flag", {30'b0, r_ecfg, r_edec}, 32'd0);
        chk("R10 type write no pulse", {31'b0, r_chg}, 32'd0);
        chk("R1 write rdata zero", r_data, 32'd0);
        access(1'b0, 12'hD90, 0);
        chk("R3 type unchanged", r_data, 32'(N) << 8);
    endtask

    task automatic t_ctrl;
        access(1'b1, 12'hD94, 32'hFFFF_FFFF);
        chk("R10 ctrl write pulse", {31'b0, r_chg}, 32'd1);
        chk("R5 no flag for 0b111", {31'b0, r_ecfg}, 32'd0);
        chk("R4 ctrl outputs", {29'b0, ctrl_priv_default, ctrl_fault_en, ctrl_enable}, 32'd7);
        access(1'b0, 12'hD94, 0);
        chk("R4 ctrl masked read", r_data, 32'd7);
        access(1'b1, 12'hD94, 32'h0000_0002);
        chk("R5 unpredictable flagged", {31'b0, r_ecfg}, 32'd1);
        chk("R5 still stored", {29'b0, ctrl_priv_default, ctrl_fault_en, ctrl_enable}, 32'd2);
        access(1'b1, 12'hD94, 32'h0000_0005);
        chk("R4 ctrl 0b101 stored", {29'b0, ctrl_priv_default, ctrl_fault_en, ctrl_enable}, 32'd5);
    endtask

    task automatic t_pointer;
        access(1'b1, 12'hD98, 32'd3);
        chk("R6 in-range accepted no flag", {31'b0, r_ecfg}, 32'd0);
        chk("R10 pointer write no pulse", {31'b0, r_chg}, 32'd0);
        access(1'b1, 12'hD98, 32'(N));
        chk("R6 out-of-range flagged", {31'b0, r_ecfg}, 32'd1);
        access(1'b0, 12'hD98, 0);
        chk("R6 pointer kept", r_data, 32'd3);
        access(1'b1, 12'hD98, 32'h0000_0013);
        chk("R6 wide value rejected", {31'b0, r_ecfg}, 32'd1);
        access(1'b0, 12'hD98, 0);
        chk("R6 pointer still kept", r_data, 32'd3);
    endtask

    task automatic t_base;
        access(1'b1, 12'hD9C, 32'h1234_566F);
        chk("R10 base write pulse", {31'b0, r_chg}, 32'd1);
        chk("R7 exported base masked", region_base[32*3 +: 32], 32'h1234_5660);
        access(1'b0, 12'hDAC, 0);
        chk("R7 base read with pointer", r_data, 32'h1234_5663);
        access(1'b1, 12'hDB4, 32'h2000_00E0);
        chk("R7 alias write", region_base[32*3 +: 32], 32'h2000_00E0);
        access(1'b0, 12'hDA4, 0);
        chk("R7 alias read", r_data, 32'h2000_00E3);
    endtask

    task automatic t_valid;
        access(1'b1, 12'hDA4, 32'h8000_0015);
        chk("R8 VALID write pulse", {31'b0, r_chg}, 32'd1);
        chk("R8 target region base", region_base[32*5 +: 32], 32'h8000_0000);
        chk("R8 old region untouched", region_base[32*3 +: 32], 32'h2000_00E0);
        access(1'b0, 12'hD98, 0);
        chk("R8 pointer updated", r_data, 32'd5);
        access(1'b1, 12'hD9C, 32'h4000_0019);
        chk("R8 out-of-range flagged", {31'b0, r_ecfg}, 32'd1);
        chk("R10 dropped write no pulse", {31'b0, r_chg}, 32'd0);
        chk("R8 current base unchanged", region_base[32*5 +: 32], 32'h8000_0000);
        access(1'b0, 12'hD98, 0);
        chk("R8 pointer kept on drop", r_data, 32'd5);
    endtask

    task automatic t_attr;
        access(1'b1, 12'hDA0, 32'hFFFF_FFFF);
        chk("R10 attr write pulse", {31'b0, r_chg}, 32'd1);
        chk("R9 size half export", {16'b0, region_size[16*5 +: 16]}, 32'h0000_FF3F);
        chk("R9 attr half export", {16'b0, region_attr[16*5 +: 16]}, 32'h0000_173F);
        access(1'b0, 12'hDB0, 0);
        chk("R9 reassembled read", r_data, 32'h173F_FF3F);
        access(1'b1, 12'hDB8, 32'h0123_4567);
        access(1'b0, 12'hDA8, 0);
        chk("R9 alias masked", r_data, 32'h0123_4527);
        chk("R9 other region untouched", {16'b0, region_size[16*3 +: 16]}, 32'd0);
    endtask

    task automatic t_unmapped;
        access(1'b0, 12'hD80, 0);
        chk("R11 unmapped read zero", r_data, 32'd0);
        chk("R11 decode flag read", {31'b0, r_edec}, 32'd1);
        access(1'b1, 12'h000, 32'hFFFF_FFFF);
        chk("R11 decode flag write", {31'b0, r_edec}, 32'd1);
        chk("R11 no pulse", {31'b0, r_chg}, 32'd0);
        access(1'b0, 12'hD94, 0);
        chk("R11 ctrl unchanged", r_data, 32'd5);
        chk("R11 mapped read no decode flag", {31'b0, r_edec}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_type();
        t_ctrl();
        t_pointer();
        t_base();
        t_valid();
        t_attr();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule